// File: doc/BRIEF.md
# Mesh Router Route Computation (XY and West-First)

This block picks the output port of a 2-D mesh router for each packet. A head flit carries the destination column and row. The router supplies its own column and row. For each head flit the block compares the two positions and names one of five ports: North, East, South, West or Local. Column (X) values grow toward East and row (Y) values grow toward North.

A mode input selects between two routing algorithms. Fixed dimension-order routing settles the column before the row. West-first turn-model routing sends any packet whose destination lies westward straight to West. It may turn only after the column matches. A packet that is not headed west may take any productive direction among North, East and South, and the block picks the one whose congestion level is lowest. Both algorithms are deadlock-free, because each one bans enough 90-degree turns to break every cyclic channel dependency.

The decision is registered with the head flit. Body and tail flits reuse it unchanged, so one packet never changes direction partway through.

Top module: `mesh_route_unit`

## Requirements
- R1: After a synchronous active-low reset, `route_valid` is 0 and `route_port` is 0. The port code is 0 Local, 1 North, 2 East, 3 South, 4 West.
- R2: `route_valid` equals `flit_valid` delayed by exactly one clock cycle. While `route_valid` is 0, `route_port` holds its last value.
- R3: In dimension-order mode (`adaptive`=0), a head flit whose destination X is greater than the local X gets East, and one whose destination X is smaller gets West, whatever the Y values are.
- R4: In dimension-order mode, a head flit whose X already matches gets North when destination Y is greater than local Y, and South when it is smaller.
- R5: In either mode, a head flit whose X and Y both match the local position gets Local.
- R6: In west-first mode (`adaptive`=1), a head flit whose destination X is smaller than the local X gets West, whatever the congestion inputs are.
- R7: In west-first mode, a head flit whose destination is not westward gets the productive direction with the smallest congestion value. A direction is productive only if it shortens the distance, and an unproductive direction is never chosen.
- R8: In west-first mode, when two or more productive directions have equal congestion, North wins over East and East wins over South.
- R9: A flit with `flit_head`=0 (body or tail) gets the port of the latest head flit. Its coordinates, mode and congestion inputs have no effect on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flit_valid | input | 1 | A flit is present this cycle |
| flit_head | input | 1 | The present flit is a head flit |
| adaptive | input | 1 | 0 selects dimension-order routing, 1 selects west-first routing |
| dest_x | input | COORD_W | Destination column carried by the head flit |
| dest_y | input | COORD_W | Destination row carried by the head flit |
| here_x | input | COORD_W | Column of this router |
| here_y | input | COORD_W | Row of this router |
| cong_n | input | CONG_W | Congestion level on the North output (larger means busier) |
| cong_e | input | CONG_W | Congestion level on the East output |
| cong_s | input | CONG_W | Congestion level on the South output |
| route_valid | output | 1 | The port for the previous cycle's flit is valid |
| route_port | output | 3 | Selected port code (0 Local, 1 North, 2 East, 3 South, 4 West) |

## Verification
Every result is due exactly one clock cycle after its flit is presented, because there is a single register between the inputs and `route_port`. The driver applies a flit on a falling edge and pushes the expected valid flag and port, stamped with the current cycle number. The monitor pops an entry only on the falling edge of a later cycle, so every comparison falls in the cycle after the rising edge that captured the flit. Idle cycles are queued as well, which checks that `route_valid` drops and that `route_port` keeps the held port in the same cycle slot.

// File: rtl/mesh_route_pkg.sv
// Shared types for the mesh route computation block.
// Assumes X grows toward East and Y grows toward North.
package mesh_route_pkg;

    // Output port codes; values are visible at the top-level port.
    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    // Which directions shorten the distance to the destination.
    typedef struct packed {
        logic north;
        logic east;
        logic south;
        logic west;
    } heading_t;

    localparam int unsigned NUM_ADAPT = 3; // adaptive candidates N, E, S

endpackage

// File: rtl/mesh_heading.sv
// Compares the destination with the local position and reports which
// directions are productive. Purely combinational. Coordinates are unsigned.
module mesh_heading
    import mesh_route_pkg::*;
#(
    parameter int unsigned COORD_W = 4
) (
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    output heading_t           heading
);

    // Magnitude comparisons per axis.
    always_comb begin
        heading.east  = (dest_x > here_x);
        heading.west  = (dest_x < here_x);
        heading.north = (dest_y > here_y);
        heading.south = (dest_y < here_y);
    end

endmodule

// File: rtl/mesh_route_dor.sv
// Dimension-order (X then Y) port selection. Combinational.
// Assumes heading bits on one axis are mutually exclusive.
module mesh_route_dor
    import mesh_route_pkg::*;
(
    input  heading_t heading,
    output port_e    port
);

    // Settle X first, then Y, then deliver locally.
    always_comb begin
        if (heading.east)       port = PORT_EAST;
        else if (heading.west)  port = PORT_WEST;
        else if (heading.north) port = PORT_NORTH;
        else if (heading.south) port = PORT_SOUTH;
        else                    port = PORT_LOCAL;
    end

endmodule

// File: rtl/mesh_route_wf.sv
// West-first turn-model port selection. Combinational.
// A westward destination forces West. Otherwise the least-congested
// productive port among N, E, S is chosen, and ties go to the lower
// candidate index (N, then E, then S). Non-productive candidates carry a
// cost above any productive cost.
module mesh_route_wf
    import mesh_route_pkg::*;
#(
    parameter int unsigned CONG_W = 3
) (
    input  heading_t            heading,
    input  logic [CONG_W-1:0]   cong_n,
    input  logic [CONG_W-1:0]   cong_e,
    input  logic [CONG_W-1:0]   cong_s,
    output port_e               port
);

    localparam int unsigned COST_W = CONG_W + 1;
    localparam int unsigned IDX_W  = $clog2(NUM_ADAPT);

    logic [CONG_W-1:0] cand_cong [NUM_ADAPT];
    logic              cand_prod [NUM_ADAPT];
    port_e             cand_port [NUM_ADAPT];
    logic [COST_W-1:0] cand_cost [NUM_ADAPT];

    logic [IDX_W-1:0]  best_idx;
    logic [COST_W-1:0] best_cost;
    logic              any_prod;

    // Candidate table in tie-break order.
    always_comb begin
        cand_cong[0] = cong_n; cand_prod[0] = heading.north; cand_port[0] = PORT_NORTH;
        cand_cong[1] = cong_e; cand_prod[1] = heading.east;  cand_port[1] = PORT_EAST;
        cand_cong[2] = cong_s; cand_prod[2] = heading.south; cand_port[2] = PORT_SOUTH;
    end

    // Cost per candidate: the MSB marks an unproductive direction.
    for (genvar g = 0; g < NUM_ADAPT; g++) begin : g_cost
        assign cand_cost[g] = {~cand_prod[g], cand_cong[g]};
    end

    // Linear minimum search; strict less-than keeps the earlier index on ties.
    always_comb begin
        best_idx  = '0;
        best_cost = cand_cost[0];
        for (int i = 1; i < NUM_ADAPT; i++) begin
            if (cand_cost[i] < best_cost) begin
                best_idx  = IDX_W'(i);
                best_cost = cand_cost[i];
            end
        end
    end

    assign any_prod = heading.north | heading.east | heading.south;

    // West has priority, then the adaptive pick, then Local.
    always_comb begin
        if (heading.west)  port = PORT_WEST;
        else if (any_prod) port = cand_port[best_idx];
        else               port = PORT_LOCAL;
    end

endmodule

// File: rtl/mesh_route_unit.sv
// Route computation unit for a 2-D mesh router.
// Computes the port for each head flit with the selected algorithm and
// registers it. Body and tail flits reuse the held port. Assumes the
// caller keeps flits of one packet contiguous on this input.
module mesh_route_unit
    import mesh_route_pkg::*;
#(
    parameter int unsigned COORD_W = 4,
    parameter int unsigned CONG_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flit_valid,
    input  logic               flit_head,
    input  logic               adaptive,
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    input  logic [CONG_W-1:0]  cong_n,
    input  logic [CONG_W-1:0]  cong_e,
    input  logic [CONG_W-1:0]  cong_s,
    output logic               route_valid,
    output logic [2:0]         route_port
);

    heading_t heading;
    port_e    dor_port;
    port_e    wf_port;
    port_e    next_port;
    port_e    held_port;
    logic     valid_q;

    mesh_heading #(.COORD_W(COORD_W)) u_heading (
        .dest_x  (dest_x),
        .dest_y  (dest_y),
        .here_x  (here_x),
        .here_y  (here_y),
        .heading (heading)
    );

    mesh_route_dor u_dor (
        .heading (heading),
        .port    (dor_port)
    );

    mesh_route_wf #(.CONG_W(CONG_W)) u_wf (
        .heading (heading),
        .cong_n  (cong_n),
        .cong_e  (cong_e),
        .cong_s  (cong_s),
        .port    (wf_port)
    );

    // Algorithm select, applied only when a head flit arrives.
    always_comb begin
        next_port = held_port;
        if (flit_valid && flit_head)
            next_port = adaptive ? wf_port : dor_port;
    end

    // Port and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_port <= PORT_LOCAL;
            valid_q   <= 1'b0;
        end else begin
            held_port <= next_port;
            valid_q   <= flit_valid;
        end
    end

    assign route_valid = valid_q;
    assign route_port  = held_port;

endmodule

// File: rtl/mesh_route_unit_chk.sv
// Assertion checker for mesh_route_unit, bound to every instance.
module mesh_route_unit_chk #(
    parameter int unsigned COORD_W = 4,
    parameter int unsigned CONG_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flit_valid,
    input logic               flit_head,
    input logic               adaptive,
    input logic [COORD_W-1:0] dest_x,
    input logic [COORD_W-1:0] dest_y,
    input logic [COORD_W-1:0] here_x,
    input logic [COORD_W-1:0] here_y,
    input logic [CONG_W-1:0]  cong_n,
    input logic [CONG_W-1:0]  cong_e,
    input logic [CONG_W-1:0]  cong_s,
    input logic               route_valid,
    input logic [2:0]         route_port
);

    logic head_now;
    assign head_now = flit_valid && flit_head;

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid |=> route_valid);

    p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flit_valid |=> (!route_valid && $stable(route_port)));

    p_dor_east_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_now && !adaptive && dest_x > here_x) |=> route_port == 3'd2);

    p_dor_west_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_now && !adaptive && dest_x < here_x) |=> route_port == 3'd4);

    p_dor_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (head_now && !adaptive && dest_x == here_x && dest_y != here_y)
        |=> (route_port == 3'd1 || route_port == 3'd3));

    p_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_now && dest_x == here_x && dest_y == here_y) |=> route_port == 3'd0);

    p_wf_west_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (head_now && adaptive && dest_x < here_x) |=> route_port == 3'd4);

    p_wf_no_west_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (head_now && adaptive && dest_x >= here_x) |=> route_port != 3'd4);

    p_body_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_head) |=> $stable(route_port));

endmodule

bind mesh_route_unit mesh_route_unit_chk #(
    .COORD_W (COORD_W),
    .CONG_W  (CONG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flit_valid  (flit_valid),
    .flit_head   (flit_head),
    .adaptive    (adaptive),
    .dest_x      (dest_x),
    .dest_y      (dest_y),
    .here_x      (here_x),
    .here_y      (here_y),
    .cong_n      (cong_n),
    .cong_e      (cong_e),
    .cong_s      (cong_s),
    .route_valid (route_valid),
    .route_port  (route_port)
);

// File: tb/test_mesh_route_unit.sv
// Scoreboard bench: the driver queues expected results and the monitor
// compares them one cycle later.
module test_mesh_route_unit;

    localparam int unsigned CW = 4;
    localparam int unsigned GW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flit_valid = 1'b0;
    logic          flit_head = 1'b0;
    logic          adaptive = 1'b0;
    logic [CW-1:0] dest_x = '0, dest_y = '0, here_x = '0, here_y = '0;
    logic [GW-1:0] cong_n = '0, cong_e = '0, cong_s = '0;
    logic          route_valid;
    logic [2:0]    route_port;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    logic [2:0] exp_port_q [$];
    bit         exp_vld_q  [$];
    int         exp_cyc_q  [$];
    string      exp_tag_q  [$];
    logic [2:0] last_port;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mesh_route_unit #(.COORD_W(CW), .CONG_W(GW)) i_mesh_route_unit (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
        .adaptive(adaptive), .dest_x(dest_x), .dest_y(dest_y),
        .here_x(here_x), .here_y(here_y), .cong_n(cong_n), .cong_e(cong_e),
        .cong_s(cong_s), .route_valid(route_valid), .route_port(route_port)
    );

    // Reference model written from the requirements (codes 0 L,1 N,2 E,3 S,4 W).
    function automatic logic [2:0] model(bit ad, int dx, int dy, int hx, int hy,
                                         int cn, int ce, int cs);
        int best; logic [2:0] p;
        if (!ad) begin
            if (dx > hx) return 3'd2;
            if (dx < hx) return 3'd4;
            if (dy > hy) return 3'd1;
            if (dy < hy) return 3'd3;
            return 3'd0;
        end
        if (dx < hx) return 3'd4;
        best = 99; p = 3'd0;
        if (dy > hy && cn < best) begin best = cn; p = 3'd1; end
        if (dx > hx && ce < best) begin best = ce; p = 3'd2; end
        if (dy < hy && cs < best) begin best = cs; p = 3'd3; end
        return p;
    endfunction

    task automatic push(bit v, logic [2:0] p, string tag);
        exp_vld_q.push_back(v);
        exp_port_q.push_back(p);
        exp_cyc_q.push_back(cyc);
        exp_tag_q.push_back(tag);
    endtask

    // Drive one flit on a falling edge and queue its expected result.
    task automatic send(bit head, bit ad, int dx, int dy, int hx, int hy,
                        int cn, int ce, int cs, string tag);
        @(negedge clk);
        flit_valid = 1'b1; flit_head = head; adaptive = ad;
        dest_x = CW'(dx); dest_y = CW'(dy); here_x = CW'(hx); here_y = CW'(hy);
        cong_n = GW'(cn); cong_e = GW'(ce); cong_s = GW'(cs);
        if (head) last_port = model(ad, dx, dy, hx, hy, cn, ce, cs);
        push(1'b1, last_port, tag);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        flit_valid = 1'b0; flit_head = 1'b0;
        dest_x = CW'(7); dest_y = CW'(1); adaptive = ~adaptive;
        push(1'b0, last_port, tag);
    endtask

    // Monitor: compare entries queued in an earlier cycle.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_cyc_q.size() > 0 && exp_cyc_q[0] < cyc) begin
                bit v; logic [2:0] p; string t;
                v = exp_vld_q.pop_front(); p = exp_port_q.pop_front();
                t = exp_tag_q.pop_front(); void'(exp_cyc_q.pop_front());
                n_checks++;
                if (route_valid !== v || route_port !== p) begin
                    n_fail++;
                    $display("FAIL %s: valid=%0b port=%0d expected valid=%0b port=%0d",
                             t, route_valid, route_port, v, p);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        last_port = 3'd0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (route_valid !== 1'b0 || route_port !== 3'd0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b port=%0d expected valid=0 port=0", route_valid, route_port);
        end
        rst_n = 1'b1;
        // R5 local in both modes
        send(1, 0, 3, 3, 3, 3, 0, 0, 0, "R5 dor local");
        send(1, 1, 5, 2, 5, 2, 0, 0, 0, "R5 wf local");
        // R3 dimension order X first
        send(1, 0, 6, 0, 2, 5, 0, 0, 0, "R3 east");
        send(1, 0, 1, 9, 4, 2, 0, 0, 0, "R3 west");
        // R4 Y after X matches
        send(1, 0, 4, 8, 4, 2, 0, 0, 0, "R4 north");
        send(1, 0, 4, 1, 4, 6, 0, 0, 0, "R4 south");
        // R6 westward forced
        send(1, 1, 0, 9, 5, 2, 0, 0, 0, "R6 west low n");
        send(1, 1, 2, 1, 3, 6, 7, 7, 0, "R6 west low s");
        // R7 least congested productive
        send(1, 1, 9, 9, 2, 2, 5, 2, 0, "R7 ne pick e");
        send(1, 1, 9, 0, 2, 5, 0, 4, 1, "R7 se pick s");
        send(1, 1, 4, 9, 4, 2, 7, 0, 0, "R7 n only");
        send(1, 1, 9, 4, 2, 4, 0, 6, 0, "R7 e only");
        // R8 ties
        send(1, 1, 9, 9, 2, 2, 3, 3, 0, "R8 tie n over e");
        send(1, 1, 9, 0, 2, 5, 0, 2, 2, "R8 tie e over s");
        // R9 body and tail reuse head decision
        send(1, 0, 8, 3, 2, 3, 0, 0, 0, "R9 head");
        send(0, 1, 0, 0, 5, 5, 0, 0, 0, "R9 body");
        send(0, 0, 5, 5, 5, 5, 0, 0, 0, "R9 tail");
        // R2 idle holds port, valid drops
        idle("R2 idle 1");
        idle("R2 idle 2");
        send(1, 1, 9, 0, 2, 5, 0, 0, 0, "R2 after idle");
        idle("R2 idle 3");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule